// File: doc/BRIEF.md
# Descriptor-Chained DMA Fetch Sequencer

This block is the control engine of a single DMA channel that takes its work from descriptors held in memory. Software loads a next-descriptor pointer, a current-descriptor pointer and a 16-bit configuration register through a small write port. A write to the configuration register with the enable bit set and a descriptor flow mode starts the channel. The block then reads the descriptor one 16-bit word at a time over a valid/ready read port and loads the fields into working registers. It hands the resulting work unit (start address, count, modify) to an external data mover and waits for that mover to report completion.

Each fetched configuration word replaces the configuration register, so the descriptor decides whether its own work unit runs, whether it raises an interrupt, and how the following descriptor is located. Three flow modes are supported. In array mode descriptors sit back to back in memory. In small-list mode each descriptor carries a 16-bit link. In large-list mode each descriptor carries a 32-bit link. A fetched flow value of zero ends the chain after that descriptor's work unit.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset the channel is idle: no memory read and no work-unit start are requested, the fetch flag and interrupt are 0, and both pointers and the configuration register read 0.
- R2: Register write addresses are 0 = next pointer, 1 = current pointer, 2 = configuration, 3 = interrupt status. In the configuration word, bit 0 is enable, bit 1 is interrupt enable and bits 6:4 are the flow mode (4 array, 6 small list, 7 large list). A configuration write in idle with bit 0 set and flow 4, 6 or 7 starts a fetch in the next cycle. Any other flow, or bit 0 clear, starts nothing.
- R3: The first descriptor is read from the next pointer in the list modes and from the current pointer in array mode.
- R4: Descriptor words are read in this fixed order. Large: link low, link high, start low, start high, config, count, modify. Small: link low, start low, start high, config, count, modify. Array: the small order without the link. The current pointer advances by 2 after each accepted word, and the fetch flag is 1 exactly while reads are requested.
- R5: The fetched config word overwrites the configuration register. If its bit 0 is clear, the channel returns to idle without starting a work unit.
- R6: A work unit is announced by a one-cycle start pulse that carries the fetched start address, count and modify. The channel then waits, with no further fetch, until the done input is asserted.
- R7: A large-mode link loads all 32 bits of the next pointer. A small-mode link replaces only bits 15:0 and keeps bits 31:16.
- R8: After done, a list-mode channel fetches from the next pointer and an array-mode channel continues at the consecutive address. A fetched flow of 0 stops the channel after its work unit.
- R9: At done, the interrupt is set if the work unit's config bit 1 is set. It stays set until a write of 1 to bit 0 at address 3. Writing 0 there leaves it unchanged.
- R10: While the read port is not ready, the request stays asserted with a stable address, and each word is read exactly once.
- R11: Writes to addresses 0 to 2 are dropped while the channel is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register write address |
| reg_wdata | input | 32 | Register write data |
| mem_rd_valid | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_ready | input | 1 | Read accepted; data valid this cycle |
| mem_rd_data | input | 16 | Descriptor word |
| wu_start | output | 1 | One-cycle work-unit start pulse |
| wu_addr | output | 32 | Work-unit start address |
| wu_count | output | 16 | Work-unit transfer count |
| wu_modify | output | 16 | Work-unit address modify |
| wu_done | input | 1 | Data mover finished the work unit |
| irq_o | output | 1 | Sticky interrupt status |
| fetching_o | output | 1 | Descriptor fetch in progress |
| next_ptr_o | output | 32 | Next-descriptor pointer |
| curr_ptr_o | output | 32 | Current-descriptor pointer |
| cfg_o | output | 16 | Configuration register |

## Verification
Two-descriptor chains are run in each of the three flow modes. Each run uses three read-port stall patterns (always ready, ready every second cycle, ready every third cycle) and both interrupt-enable settings of the first descriptor. Comparing the logged read addresses with addresses computed from the mode separates the word orders, the array continuation and the small versus large link handling. The stall patterns separate a correct hold from dropped or duplicated reads. Directed cases cover the non-starting configuration writes, a fetched descriptor with enable cleared, writes made while busy, and the write-0 versus write-1 behaviour of the interrupt clear.

// File: rtl/dma_desc_pkg.sv
// Shared constants, types and decode helpers for the descriptor sequencer.
// Assumes 16-bit descriptor words and 32-bit byte addresses.
package dma_desc_pkg;
    localparam int ADDR_W       = 32;
    localparam int WORD_W       = 16;
    localparam int STEP_BYTES   = WORD_W / 8;
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_IE_BIT   = 1;
    localparam int CFG_FLOW_LSB = 4;
    localparam int FLOW_W       = 3;
    localparam int IDX_W        = 3;
    localparam int RADDR_W      = 2;

    localparam logic [RADDR_W-1:0] REG_NEXT = 2'd0;
    localparam logic [RADDR_W-1:0] REG_CURR = 2'd1;
    localparam logic [RADDR_W-1:0] REG_CFG  = 2'd2;
    localparam logic [RADDR_W-1:0] REG_IRQ  = 2'd3;

    localparam logic [FLOW_W-1:0] FLOW_STOP  = 3'd0;
    localparam logic [FLOW_W-1:0] FLOW_ARRAY = 3'd4;
    localparam logic [FLOW_W-1:0] FLOW_SMALL = 3'd6;
    localparam logic [FLOW_W-1:0] FLOW_LARGE = 3'd7;

    typedef enum logic [IDX_W-1:0] {
        FLD_LINK_LO, FLD_LINK_HI, FLD_SA_LO, FLD_SA_HI, FLD_CFG, FLD_CNT, FLD_MOD
    } field_e;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DISPATCH, ST_RUN} state_e;

    // True for a flow value that runs descriptors.
    function automatic logic flow_runs(input logic [FLOW_W-1:0] f);
        return (f == FLOW_ARRAY) || (f == FLOW_SMALL) || (f == FLOW_LARGE);
    endfunction

    // True for the two linked-list flows.
    function automatic logic flow_is_list(input logic [FLOW_W-1:0] f);
        return (f == FLOW_SMALL) || (f == FLOW_LARGE);
    endfunction

    // Number of words in a descriptor of the given flow.
    function automatic logic [IDX_W-1:0] words_in(input logic [FLOW_W-1:0] f);
        case (f)
            FLOW_LARGE: return 3'd7;
            FLOW_SMALL: return 3'd6;
            default:    return 3'd5;
        endcase
    endfunction

    // Field carried by word idx of a descriptor of the given flow.
    function automatic field_e field_at(input logic [FLOW_W-1:0] f, input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] code;
        case (f)
            FLOW_LARGE: code = idx;
            FLOW_SMALL: code = (idx == 3'd0) ? 3'd0 : idx + 3'd1;
            default:    code = idx + 3'd2;
        endcase
        return field_e'(code);
    endfunction
endpackage

// File: rtl/dma_desc_fetch.sv
// Word reader: walks through the words of one descriptor over a valid/ready
// read port and tags each accepted word with the field it carries.
// Assumes the address input advances by one word on every accepted read.
module dma_desc_fetch
    import dma_desc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [FLOW_W-1:0] mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              take,
    output field_e            take_field,
    output logic [WORD_W-1:0] take_data,
    output logic              take_last
);
    logic [IDX_W-1:0] idx_q;

    // Request and word tagging follow the current index.
    always_comb begin
        mem_rd_valid = active;
        mem_rd_addr  = addr;
        take         = active && mem_rd_ready;
        take_field   = field_at(mode, idx_q);
        take_data    = mem_rd_data;
        take_last    = take && (idx_q == (words_in(mode) - 3'd1));
    end

    // Word index within the descriptor, cleared between descriptors.
    always_ff @(posedge clk) begin
        if (!rst_n)                   idx_q <= '0;
        else if (!active || take_last) idx_q <= '0;
        else if (take)                 idx_q <= idx_q + 3'd1;
    end

    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx_q < words_in(mode)));
endmodule

// File: rtl/dma_desc_regs.sv
// Channel register set: software-visible pointers and configuration, working
// registers of the current work unit, and the sticky interrupt status.
// Assumes sw_allow is low whenever fetched words or pointer reloads arrive.
module dma_desc_regs
    import dma_desc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_we,
    input  logic [RADDR_W-1:0] sw_addr,
    input  logic [ADDR_W-1:0]  sw_data,
    input  logic               sw_allow,
    input  logic               take,
    input  field_e             take_field,
    input  logic [WORD_W-1:0]  take_data,
    input  logic               load_curr,
    input  logic               irq_set,
    output logic [ADDR_W-1:0]  next_ptr,
    output logic [ADDR_W-1:0]  curr_ptr,
    output logic [WORD_W-1:0]  cfg,
    output logic [ADDR_W-1:0]  wu_addr,
    output logic [WORD_W-1:0]  wu_count,
    output logic [WORD_W-1:0]  wu_modify,
    output logic               irq
);
    localparam int HALF = ADDR_W / 2;

    logic sw_ok, irq_clr;
    assign sw_ok   = sw_we && sw_allow;
    assign irq_clr = sw_we && (sw_addr == REG_IRQ) && sw_data[0];

    // Next pointer: software write, or link halves from the descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) next_ptr <= '0;
        else if (sw_ok && sw_addr == REG_NEXT) next_ptr <= sw_data;
        else if (take && take_field == FLD_LINK_LO) next_ptr[HALF-1:0] <= take_data;
        else if (take && take_field == FLD_LINK_HI) next_ptr[ADDR_W-1:HALF] <= take_data;
    end

    // Current pointer: software write, reload from the link, or word step.
    always_ff @(posedge clk) begin
        if (!rst_n) curr_ptr <= '0;
        else if (sw_ok && sw_addr == REG_CURR) curr_ptr <= sw_data;
        else if (load_curr) curr_ptr <= next_ptr;
        else if (take) curr_ptr <= curr_ptr + ADDR_W'(STEP_BYTES);
    end

    // Configuration: software write or overwrite by the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= '0;
        else if (sw_ok && sw_addr == REG_CFG) cfg <= sw_data[WORD_W-1:0];
        else if (take && take_field == FLD_CFG) cfg <= take_data;
    end

    // Work-unit fields loaded from the descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wu_addr   <= '0;
            wu_count  <= '0;
            wu_modify <= '0;
        end else if (take) begin
            case (take_field)
                FLD_SA_LO: wu_addr[HALF-1:0]      <= take_data;
                FLD_SA_HI: wu_addr[ADDR_W-1:HALF] <= take_data;
                FLD_CNT:   wu_count               <= take_data;
                FLD_MOD:   wu_modify              <= take_data;
                default:   ;
            endcase
        end
    end

    // Sticky interrupt; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (curr_ptr == $past(curr_ptr) + ADDR_W'(STEP_BYTES)));

    a_r7_low_link_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_field == FLD_LINK_LO) |=> (next_ptr[ADDR_W-1:HALF] == $past(next_ptr[ADDR_W-1:HALF])));

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/dma_desc_seq.sv
// Descriptor-chained DMA fetch sequencer, top level. Sequences start-up,
// descriptor fetch, work-unit dispatch, completion and chaining for one channel.
// Assumes the data mover pulses wu_done once per announced work unit.
module dma_desc_seq
    import dma_desc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [ADDR_W-1:0]  reg_wdata,
    output logic               mem_rd_valid,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_ready,
    input  logic [WORD_W-1:0]  mem_rd_data,
    output logic               wu_start,
    output logic [ADDR_W-1:0]  wu_addr,
    output logic [WORD_W-1:0]  wu_count,
    output logic [WORD_W-1:0]  wu_modify,
    input  logic               wu_done,
    output logic               irq_o,
    output logic               fetching_o,
    output logic [ADDR_W-1:0]  next_ptr_o,
    output logic [ADDR_W-1:0]  curr_ptr_o,
    output logic [WORD_W-1:0]  cfg_o
);
    state_e            state_q, state_d;
    logic [FLOW_W-1:0] mode_q, wr_flow, cfg_flow;
    logic              start_go, run_end, load_curr, irq_set;
    logic              take, take_last;
    field_e            take_field;
    logic [WORD_W-1:0] take_data;

    // Decode of the start condition, completion and chaining controls.
    always_comb begin
        wr_flow    = reg_wdata[CFG_FLOW_LSB +: FLOW_W];
        cfg_flow   = cfg_o[CFG_FLOW_LSB +: FLOW_W];
        start_go   = (state_q == ST_IDLE) && reg_wr_en && (reg_addr == REG_CFG)
                     && reg_wdata[CFG_EN_BIT] && flow_runs(wr_flow);
        run_end    = (state_q == ST_RUN) && wu_done;
        load_curr  = (start_go && flow_is_list(wr_flow)) || (run_end && flow_is_list(cfg_flow));
        irq_set    = run_end && cfg_o[CFG_IE_BIT];
        wu_start   = (state_q == ST_DISPATCH) && cfg_o[CFG_EN_BIT];
        fetching_o = (state_q == ST_FETCH);
    end

    // Next-state logic of the channel sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (start_go) state_d = ST_FETCH;
            ST_FETCH:    if (take_last) state_d = ST_DISPATCH;
            ST_DISPATCH: state_d = cfg_o[CFG_EN_BIT] ? ST_RUN : ST_IDLE;
            ST_RUN:      if (run_end) state_d = flow_runs(cfg_flow) ? ST_FETCH : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and the flow mode used by the coming fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= FLOW_STOP;
        end else begin
            state_q <= state_d;
            if (start_go) mode_q <= wr_flow;
            else if (run_end && flow_runs(cfg_flow)) mode_q <= cfg_flow;
        end
    end

    dma_desc_fetch u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (fetching_o),
        .mode         (mode_q),
        .addr         (curr_ptr_o),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data),
        .take         (take),
        .take_field   (take_field),
        .take_data    (take_data),
        .take_last    (take_last)
    );

    dma_desc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we      (reg_wr_en),
        .sw_addr    (reg_addr),
        .sw_data    (reg_wdata),
        .sw_allow   (state_q == ST_IDLE),
        .take       (take),
        .take_field (take_field),
        .take_data  (take_data),
        .load_curr  (load_curr),
        .irq_set    (irq_set),
        .next_ptr   (next_ptr_o),
        .curr_ptr   (curr_ptr_o),
        .cfg        (cfg_o),
        .wu_addr    (wu_addr),
        .wu_count   (wu_count),
        .wu_modify  (wu_modify),
        .irq        (irq_o)
    );

    a_r2_fetch_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> fetching_o);

    a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wu_start |-> cfg_o[CFG_EN_BIT]);

    a_r6_start_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wu_start |=> !wu_start);

    a_r8_stop_on_flow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run_end && !flow_runs(cfg_flow)) |=> (!fetching_o && !wu_start));
endmodule

// File: tb/dma_desc_seq_test.sv
// Self-checking bench: sweeps two-descriptor chains over every flow mode,
// several read-port stall patterns and both interrupt settings, plus directed cases.
module dma_desc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_rd_valid, mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic [15:0] mem_rd_data;
    logic        wu_start, wu_done = 1'b0;
    logic [31:0] wu_addr;
    logic [15:0] wu_count, wu_modify;
    logic        irq_o, fetching_o;
    logic [31:0] next_ptr_o, curr_ptr_o;
    logic [15:0] cfg_o;

    int checks = 0, errors = 0;
    int stall_sel = 0, cyc = 0, rd_n = 0, starts = 0, flag_bad = 0;
    logic [31:0] rd_log [0:31];
    logic [15:0] mem [0:511];

    always #5 clk = ~clk;

    assign mem_rd_data = mem[mem_rd_addr[9:1]];

    dma_desc_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data), .wu_start(wu_start),
        .wu_addr(wu_addr), .wu_count(wu_count), .wu_modify(wu_modify), .wu_done(wu_done),
        .irq_o(irq_o), .fetching_o(fetching_o), .next_ptr_o(next_ptr_o),
        .curr_ptr_o(curr_ptr_o), .cfg_o(cfg_o)
    );

    // Port monitor: drives ready for the coming edge and logs accepted reads.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            mem_rd_ready = (stall_sel == 0) ? 1'b1 : ((cyc % (stall_sel + 1)) == 0);
            if (mem_rd_valid && mem_rd_ready) begin
                if (rd_n < 32) rd_log[rd_n] = mem_rd_addr;
                rd_n = rd_n + 1;
            end
            if (wu_start) starts = starts + 1;
            if (mem_rd_valid != fetching_o) flag_bad = flag_bad + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic int nwords(input int mode);
        return (mode == 7) ? 7 : (mode == 6) ? 6 : 5;
    endfunction

    task automatic put_desc(input int mode, input logic [31:0] base, input logic [31:0] lnk,
                            input logic [31:0] sa, input logic [15:0] cf,
                            input logic [15:0] cn, input logic [15:0] md);
        logic [15:0] w [0:6];
        int n;
        n = 0;
        if (mode == 7) begin w[0] = lnk[15:0]; w[1] = lnk[31:16]; n = 2; end
        else if (mode == 6) begin w[0] = lnk[15:0]; n = 1; end
        w[n] = sa[15:0]; w[n+1] = sa[31:16]; w[n+2] = cf; w[n+3] = cn; w[n+4] = md;
        n = n + 5;
        for (int k = 0; k < n; k++) mem[base[9:1] + 9'(k)] = w[k];
    endtask

    task automatic wait_start(output bit seen);
        seen = 0;
        for (int t = 0; t < 300 && !seen; t++) begin
            @(negedge clk);
            if (wu_start) seen = 1;
        end
    endtask

    task automatic pulse_done();
        @(negedge clk); wu_done = 1'b1;
        @(negedge clk); wu_done = 1'b0;
    endtask

    // One two-descriptor chain; desc 1 runs in the given mode, desc 2 stops.
    task automatic run_case(input int mode, input int stall, input int ie, input int run);
        int W, bad, s0;
        bit seen;
        logic [31:0] b1, b2, init_next, lnk1, lnk2, sa1, sa2, exp_next, e;
        logic [15:0] cfg1, cfg2, cnt1, cnt2;
        string rtag;
        W = nwords(mode);
        lnk1 = (mode == 7) ? 32'h0007_0180 : 32'h0000_0180;
        lnk2 = (mode == 7) ? 32'h0009_0300 : 32'h0000_0300;
        if (mode == 4) begin
            b1 = 32'h0000_0100; b2 = b1 + 32'(2 * W); init_next = 32'h1234_5678; exp_next = init_next;
        end else begin
            init_next = 32'h0002_0100; b1 = init_next;
            b2 = (mode == 7) ? lnk1 : {16'h0002, lnk1[15:0]};
            exp_next = (mode == 7) ? lnk2 : {16'h0002, lnk2[15:0]};
        end
        sa1 = 32'hA000_0010 + 32'(run * 256); sa2 = 32'hB000_0000 + 32'(run);
        cnt1 = 16'(10 + run); cnt2 = 16'(100 + run);
        cfg1 = 16'((mode << 4) | (ie << 1) | 1); cfg2 = 16'h0001;
        put_desc(mode, b1, lnk1, sa1, cfg1, cnt1, 16'h0002);
        put_desc(mode, b2, lnk2, sa2, cfg2, cnt2, 16'hFFFE);
        stall_sel = stall; rd_n = 0; s0 = starts;
        if (mode == 4) begin wr(2'd0, init_next); wr(2'd1, b1); end
        else begin wr(2'd0, init_next); wr(2'd1, 32'h0000_0040); end
        wr(2'd2, 32'((mode << 4) | 1));
        wait_start(seen);
        check("R6", {wu_addr, wu_count, wu_modify}, {sa1, cnt1, 16'h0002}, "first work unit");
        check("R3", rd_log[0], b1, "first descriptor address");
        // R11: writes while busy are dropped (checked via final pointer and chain).
        wr(2'd0, 32'hDEAD_BEEF);
        wr(2'd2, 32'h0000_0000);
        repeat (3) @(negedge clk);
        check("R6", {31'd0, fetching_o, 31'd0, wu_start}, 64'd0, "idle wait before done");
        pulse_done();
        wait_start(seen);
        check("R8", {wu_addr, wu_count, wu_modify}, {sa2, cnt2, 16'hFFFE}, "second work unit");
        check("R9", {63'd0, irq_o}, 64'(ie), "irq after first done");
        pulse_done();
        repeat (4) @(negedge clk);
        check("R8", {31'd0, fetching_o, 32'(starts - s0)}, {32'd0, 32'd2}, "stop after flow 0");
        check("R8", curr_ptr_o, b2 + 32'(2 * W), "final current pointer");
        check("R7", next_ptr_o, exp_next, "next pointer after links");
        check("R11", {48'd0, cfg_o}, {48'd0, cfg2}, "config is fetched word, not busy write");
        rtag = (stall > 0) ? "R10" : "R4";
        bad = -1;
        for (int k = 0; k < 2 * W && k < 32; k++) begin
            e = (k < W) ? b1 + 32'(2 * k) : b2 + 32'(2 * (k - W));
            if (bad < 0 && rd_log[k] !== e) bad = k;
        end
        check(rtag, 64'(rd_n), 64'(2 * W), "number of words read");
        if (bad >= 0) begin
            e = (bad < W) ? b1 + 32'(2 * bad) : b2 + 32'(2 * (bad - W));
            check(rtag, rd_log[bad], e, "read address order");
        end else check(rtag, 1, 1, "read address order");
        check("R9", {63'd0, irq_o}, 64'(ie), "irq held until cleared");
        wr(2'd3, 32'h1);
        @(negedge clk);
        check("R9", {63'd0, irq_o}, 64'd0, "irq cleared by write 1");
        stall_sel = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0, r0, run;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {mem_rd_valid, wu_start, fetching_o, irq_o, 60'd0}, 64'd0, "reset flags");
        check("R1", {next_ptr_o, curr_ptr_o}, 64'd0, "reset pointers");
        check("R1", {48'd0, cfg_o}, 64'd0, "reset config");

        // R2 non-starting configuration writes
        r0 = rd_n;
        wr(2'd2, 32'h0000_0001);
        repeat (3) @(negedge clk);
        check("R2", {63'd0, fetching_o}, 64'd0, "flow 0 with enable");
        wr(2'd2, 32'h0000_0060);
        repeat (3) @(negedge clk);
        check("R2", {63'd0, fetching_o}, 64'd0, "small flow, enable clear");
        wr(2'd2, 32'h0000_0051);
        repeat (3) @(negedge clk);
        check("R2", 64'(rd_n - r0), 64'd0, "flow 5 with enable");

        // R5 fetched config with enable clear stops the channel
        put_desc(6, 32'h0000_0200, 32'h0000_0280, 32'hC000_0000, 16'h0062, 16'd7, 16'd1);
        s0 = starts;
        wr(2'd0, 32'h0000_0200);
        wr(2'd2, 32'h0000_0061);
        repeat (20) @(negedge clk);
        check("R5", {48'd0, cfg_o}, {48'd0, 16'h0062}, "config overwritten by fetch");
        check("R5", {31'd0, fetching_o, 32'(starts - s0)}, 64'd0, "no work unit, idle");
        check("R5", curr_ptr_o, 32'h0000_020C, "pointer after six words");
        check("R7", next_ptr_o, 32'h0000_0280, "small link loaded");

        // Sweep over modes, stall patterns and interrupt enable
        run = 0;
        for (int mi = 0; mi < 3; mi++) begin
            for (int st = 0; st < 3; st++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    run_case((mi == 0) ? 4 : (mi == 1) ? 6 : 7, st, ie, run);
                    run++;
                end
            end
        end
        check("R4", 64'(flag_bad), 64'd0, "fetch flag matches read requests");

        // R9 write 0 leaves irq set, write 1 clears
        put_desc(4, 32'h0000_0300, 32'h0, 32'hD000_0000, 16'h0003, 16'd1, 16'd1);
        wr(2'd1, 32'h0000_0300);
        wr(2'd2, 32'h0000_0041);
        begin
            bit seen;
            wait_start(seen);
        end
        pulse_done();
        repeat (2) @(negedge clk);
        wr(2'd3, 32'h0);
        @(negedge clk);
        check("R9", {63'd0, irq_o}, 64'd1, "write 0 keeps irq");
        wr(2'd3, 32'h1);
        @(negedge clk);
        check("R9", {63'd0, irq_o}, 64'd0, "write 1 clears irq");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule